// File: doc/BRIEF.md
# Interrupt Cause Collector with Moderation Timers

This block gathers interrupt causes from a network controller's receive and transmit paths into a pending register. It then gates that register with a mask and drives one level interrupt line to the host. Causes posted on the ordinary path are throttled by a rate-limit interval. After the line rises, further ordinary posts cannot raise it again until the interval has run out. A single free-running prescaler produces a tick every `TICK_DIV` clock cycles, which is 1024 ns at 125 MHz with the default of 128. Every timer in the block counts in these ticks.

Four delay timers sit beside the cause logic. Receive traffic arms a packet-delay timer and an absolute-delay timer. Transmit traffic arms an idle-delay timer and an absolute-delay timer. When a timer in either pair runs out, the block emits a one-cycle request for an unaligned descriptor writeback on that path. It also posts the path's cause immediately, without the rate limiter. The descriptor logic that serves the request lives elsewhere.

Software reaches the block through a small write port that carries the mask, the four delay values and the rate-limit interval. A read-clear strobe empties the pending register.

Top module: `irq_moderator`

## Requirements
- R1: A tick occurs every `TICK_DIV` cycles after reset release. A timer loaded with value v at one clock edge expires between (v-1)*TICK_DIV+1 and v*TICK_DIV edges later, and a value of 1 expires within `TICK_DIV` edges.
- R2: The receive packet-delay timer (`cfg_sel` 1) reloads from its value on every `rx_pkt` strobe, so each strobe pushes its expiry back.
- R3: The receive absolute-delay timer (`cfg_sel` 2) loads on an `rx_pkt` strobe only when it is idle. Strobes that arrive while it runs do not move its expiry.
- R4: The transmit idle-delay timer (`cfg_sel` 4) reloads on every `tx_pkt` strobe. The transmit absolute-delay timer (`cfg_sel` 3) loads only when it is idle.
- R5: When either receive timer expires, `rx_wb_req` is high for exactly one cycle and pending bit 1 is set in that same cycle. Both receive timers stop, and an `rx_pkt` strobe in the expiry cycle is discarded.
- R6: When either transmit timer expires, `tx_wb_req` is high for one cycle and pending bit 0 is set in that same cycle. Both transmit timers stop.
- R7: When a timer expires and its cause bit is masked in, `irq` is high in the same cycle as the writeback request, even while the rate limiter is running.
- R8: On the ordinary path, `cause_in` bits and `tx_wb_done` (bit 0) set pending bits one edge later. `irq` rises at that edge if a masked-in bit is pending and the limiter is idle.
- R9: Each rising edge of `irq` loads the limiter with the interval (`cfg_sel` 5). While it runs, ordinary posts leave `irq` low. When it expires, `irq` rises if a masked-in cause is pending.
- R10: A mask write (`cfg_sel` 0, low `CAUSE_W` data bits) re-evaluates the pending causes. It raises `irq` if a newly enabled cause is pending and the limiter is idle, and it drops `irq` if no enabled cause remains.
- R11: `pend_rd` clears the pending register and drops `irq`. Causes posted in the same cycle survive the clear.
- R12: After reset, `pend_o`, `irq` and both writeback requests are zero and all values are zero. A delay value of zero disables its timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mask, 1 rx packet delay, 2 rx absolute, 3 tx absolute, 4 tx idle, 5 rate interval |
| cfg_data | input | VAL_W | Write data |
| cause_in | input | CAUSE_W | Ordinary cause strobes, one per bit |
| tx_wb_done | input | 1 | Transmit descriptor writeback finished; ordinary post of bit 0 |
| rx_pkt | input | 1 | Receive packet landed; arms the receive timers |
| tx_pkt | input | 1 | Transmit packet queued; arms the transmit timers |
| pend_rd | input | 1 | Read-clear of the pending register |
| pend_o | output | CAUSE_W | Pending causes |
| rx_wb_req | output | 1 | One-cycle unaligned receive writeback request |
| tx_wb_req | output | 1 | One-cycle unaligned transmit writeback request |
| irq | output | 1 | Interrupt line to the host |

## Verification
Directed sequences check the timers in isolation. A single strobe measures the tick scaling. A second strobe partway through a timer separates the restarting timers from the absolute ones. Both receive timers armed together show that the first expiry cancels the other. A post while the limiter runs is separated from a timer expiry under the same limiter, which separates the deferred path from the bypass path. Mask writes with a cause already pending show re-evaluation in both directions. A long stretch of seeded random strobes, clears and register writes then runs against a cycle model held in the bench. These mixes hit arm/expire collisions and clears that coincide with posts at every prescaler phase.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  typedef enum logic [2:0] {
    SEL_MASK    = 3'd0,
    SEL_RX_PKT  = 3'd1,
    SEL_RX_ABS  = 3'd2,
    SEL_TX_ABS  = 3'd3,
    SEL_TX_IDLE = 3'd4,
    SEL_RATE    = 3'd5
  } cfg_sel_e;

  localparam int NUM_DLY     = 4;
  localparam int DLY_RX_PKT  = 0;
  localparam int DLY_RX_ABS  = 1;
  localparam int DLY_TX_ABS  = 2;
  localparam int DLY_TX_IDLE = 3;
  // per delay timer: 1 = every arm reloads, 0 = arm only when idle
  localparam logic [NUM_DLY-1:0] DLY_RESTART = 4'b1001;

  localparam int BIT_TXW = 0;  // transmit descriptors written
  localparam int BIT_RXT = 1;  // receive timer
endpackage

// File: rtl/irq_mod_tick.sv
module irq_mod_tick #(
  parameter int TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pc_q, pc_n;

  assign tick = (pc_q == PW'(TICK_DIV - 1));

  always_comb begin
    pc_n = tick ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_n;
  end
endmodule

// File: rtl/irq_mod_timer.sv
module irq_mod_timer #(
  parameter int W       = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         arm,
  input  logic         cancel,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         do_load, do_dec;

  assign expire = tick && (cnt_q == W'(1));

  always_comb begin
    do_load = arm && (load_val != '0) && (RESTART || (cnt_q == '0));
    do_dec  = tick && (cnt_q != '0);
    cnt_n   = cnt_q;
    if (cancel)       cnt_n = '0;
    else if (do_load) cnt_n = load_val;
    else if (do_dec)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/irq_mod_limiter.sv
module irq_mod_limiter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] interval,
  output logic         busy,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_n;

  assign busy   = (cnt_q != '0);
  assign expire = tick && (cnt_q == W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (start && (interval != '0)) cnt_n = interval;
    else if (tick && busy)         cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/irq_mod_cfg.sv
module irq_mod_cfg
  import irq_mod_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [2:0]                      sel,
  input  logic [VAL_W-1:0]                data,
  output logic [NUM_DLY-1:0][VAL_W-1:0]   dly_val,
  output logic [VAL_W-1:0]                rate_val
);
  logic [VAL_W-1:0] rate_n;

  for (genvar i = 0; i < NUM_DLY; i++) begin : g_val
    localparam logic [2:0] MY_SEL = 3'(int'(SEL_RX_PKT) + i);
    logic [VAL_W-1:0] val_q, val_n;
    logic             hit;

    assign hit = we && (sel == MY_SEL);

    always_comb begin
      val_n = hit ? data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_n;
    end

    assign dly_val[i] = val_q;
  end

  always_comb begin
    rate_n = (we && (sel == SEL_RATE)) ? data : rate_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_val <= '0;
    else        rate_val <= rate_n;
  end
endmodule

// File: rtl/irq_mod_cause.sv
module irq_mod_cause #(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [CAUSE_W-1:0] mask_data,
  input  logic [CAUSE_W-1:0] norm_set,
  input  logic [CAUSE_W-1:0] fast_set,
  input  logic               rd_clr,
  input  logic               lim_busy,
  input  logic               lim_exp,
  output logic [CAUSE_W-1:0] pend_q,
  output logic [CAUSE_W-1:0] mask_q,
  output logic               irq_q,
  output logic               irq_rise
);
  logic [CAUSE_W-1:0] pend_n, mask_n;
  logic               hit, fire, irq_n;

  always_comb begin
    pend_n = (rd_clr ? '0 : pend_q) | norm_set | fast_set;
    mask_n = mask_we ? mask_data : mask_q;
    hit    = |(pend_n & mask_n);
    // immediate posts and limiter expiry always evaluate; ordinary posts
    // and mask writes only when the limiter is idle
    fire   = (|fast_set) || lim_exp || (((|norm_set) || mask_we) && !lim_busy);
    if (!hit)      irq_n = 1'b0;
    else if (fire) irq_n = 1'b1;
    else           irq_n = irq_q;
  end

  assign irq_rise = irq_n && !irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      mask_q <= mask_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int CAUSE_W  = 8,
  parameter int VAL_W    = 16,
  parameter int TICK_DIV = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [VAL_W-1:0]   cfg_data,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               tx_wb_done,
  input  logic               rx_pkt,
  input  logic               tx_pkt,
  input  logic               pend_rd,
  output logic [CAUSE_W-1:0] pend_o,
  output logic               rx_wb_req,
  output logic               tx_wb_req,
  output logic               irq
);
  logic                          rst_s1_q, rst_sync_n;
  logic                          tick;
  logic [NUM_DLY-1:0][VAL_W-1:0] dly_val;
  logic [VAL_W-1:0]              rate_val;
  logic [NUM_DLY-1:0]            dly_exp;
  logic                          rx_exp, tx_exp;
  logic [CAUSE_W-1:0]            norm_set, fast_set, mask_q;
  logic                          mask_we;
  logic                          lim_busy, lim_exp, irq_rise;
  logic                          rx_req_n, tx_req_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  irq_mod_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  irq_mod_cfg #(.VAL_W(VAL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .data     (cfg_data),
    .dly_val  (dly_val),
    .rate_val (rate_val)
  );

  assign rx_exp = dly_exp[DLY_RX_PKT] | dly_exp[DLY_RX_ABS];
  assign tx_exp = dly_exp[DLY_TX_ABS] | dly_exp[DLY_TX_IDLE];

  for (genvar i = 0; i < NUM_DLY; i++) begin : g_dly
    localparam bit IS_RX = (i == DLY_RX_PKT) || (i == DLY_RX_ABS);
    irq_mod_timer #(.W(VAL_W), .RESTART(DLY_RESTART[i])) u_tmr (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick     (tick),
      .arm      (IS_RX ? rx_pkt : tx_pkt),
      .cancel   (IS_RX ? rx_exp : tx_exp),
      .load_val (dly_val[i]),
      .expire   (dly_exp[i])
    );
  end

  irq_mod_limiter #(.W(VAL_W)) u_lim (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .start    (irq_rise),
    .interval (rate_val),
    .busy     (lim_busy),
    .expire   (lim_exp)
  );

  always_comb begin
    norm_set          = cause_in;
    norm_set[BIT_TXW] = cause_in[BIT_TXW] | tx_wb_done;
    fast_set          = '0;
    fast_set[BIT_TXW] = tx_exp;
    fast_set[BIT_RXT] = rx_exp;
    mask_we           = cfg_we && (cfg_sel == SEL_MASK);
    rx_req_n          = rx_exp;
    tx_req_n          = tx_exp;
  end

  irq_mod_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mask_we   (mask_we),
    .mask_data (cfg_data[CAUSE_W-1:0]),
    .norm_set  (norm_set),
    .fast_set  (fast_set),
    .rd_clr    (pend_rd),
    .lim_busy  (lim_busy),
    .lim_exp   (lim_exp),
    .pend_q    (pend_o),
    .mask_q    (mask_q),
    .irq_q     (irq),
    .irq_rise  (irq_rise)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_wb_req <= 1'b0;
      tx_wb_req <= 1'b0;
    end else begin
      rx_wb_req <= rx_req_n;
      tx_wb_req <= tx_req_n;
    end
  end
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int CAUSE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic [CAUSE_W-1:0] pend,
  input logic [CAUSE_W-1:0] irq_mask,
  input logic               rd_clr,
  input logic [CAUSE_W-1:0] cause_in,
  input logic               tx_wb_done,
  input logic               rx_wb_req,
  input logic               tx_wb_req
);
  // R8 / R10: line only high with an enabled pending cause
  a_r8_line_has_masked_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & irq_mask) != '0));

  // R11: a read with no new post leaves the register empty
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (cause_in == '0) && !tx_wb_done) |=> (rx_wb_req || tx_wb_req || (pend == '0)));

  // R5: receive expiry sets the receive-timer cause with the request
  a_r5_rx_post: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |-> pend[1]);

  // R5: the request is a single-cycle pulse
  a_r5_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |=> !rx_wb_req);

  // R6: transmit expiry sets the descriptors-written cause
  a_r6_tx_post: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_req |-> pend[0]);

  // R7: an enabled expiry cause drives the line at once
  a_r7_rx_expiry_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wb_req && irq_mask[1]) |-> irq);

  a_r7_tx_expiry_line: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wb_req && irq_mask[0]) |-> irq);
endmodule

bind irq_moderator irq_moderator_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .irq        (irq),
  .pend       (pend_o),
  .irq_mask   (mask_q),
  .rd_clr     (pend_rd),
  .cause_in   (cause_in),
  .tx_wb_done (tx_wb_done),
  .rx_wb_req  (rx_wb_req),
  .tx_wb_req  (tx_wb_req)
);

// File: tb/irq_moderator_tb.sv
`timescale 1ns/1ps
module irq_moderator_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_data;
  logic [7:0]  cause_in;
  logic        tx_wb_done, rx_pkt, tx_pkt, pend_rd;
  logic [7:0]  pend_o;
  logic        rx_wb_req, tx_wb_req, irq;

  always #4 clk = ~clk;

  irq_moderator #(.CAUSE_W(8), .VAL_W(16), .TICK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cause_in(cause_in), .tx_wb_done(tx_wb_done),
    .rx_pkt(rx_pkt), .tx_pkt(tx_pkt), .pend_rd(pend_rd), .pend_o(pend_o),
    .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  int       m_pc, m_lim, m_rate;
  int       m_cnt [4];
  int       m_val [4];
  bit [7:0] m_pend, m_mask;
  bit       m_irq, m_rxwb, m_txwb;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_lim = 0; m_rate = 0; m_pend = '0; m_mask = '0;
    m_irq = 0; m_rxwb = 0; m_txwb = 0;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_val[i] = 0; end
  endtask

  task automatic model_step();
    bit tk, rxe, txe, lexp, lbusy, mwr, hit, fire, in_irq, rise;
    bit [3:0] e;
    bit [7:0] norm, fast, pn, mn;
    tk = (m_pc == D - 1);
    for (int i = 0; i < 4; i++) e[i] = tk && (m_cnt[i] == 1);
    rxe   = e[0] | e[1];
    txe   = e[2] | e[3];
    lexp  = tk && (m_lim == 1);
    lbusy = (m_lim != 0);
    norm  = cause_in | {7'b0, tx_wb_done};
    fast  = {6'b0, rxe, txe};
    pn    = (pend_rd ? 8'h00 : m_pend) | norm | fast;
    mwr   = cfg_we && (cfg_sel == 3'd0);
    mn    = mwr ? cfg_data[7:0] : m_mask;
    hit   = (pn & mn) != 0;
    fire  = rxe || txe || lexp || (((norm != 0) || mwr) && !lbusy);
    in_irq = !hit ? 1'b0 : (fire ? 1'b1 : m_irq);
    rise  = in_irq && !m_irq;
    for (int i = 0; i < 4; i++) begin
      bit arm, can, rst;
      arm = (i < 2) ? rx_pkt : tx_pkt;
      can = (i < 2) ? rxe : txe;
      rst = (i == 0) || (i == 3);
      if (can) m_cnt[i] = 0;
      else if (arm && m_val[i] != 0 && (rst || m_cnt[i] == 0)) m_cnt[i] = m_val[i];
      else if (tk && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
    end
    if (rise && m_rate != 0) m_lim = m_rate;
    else if (tk && m_lim != 0) m_lim = m_lim - 1;
    if (cfg_we && cfg_sel >= 3'd1 && cfg_sel <= 3'd4) m_val[cfg_sel - 1] = int'(cfg_data);
    if (cfg_we && cfg_sel == 3'd5) m_rate = int'(cfg_data);
    m_pend = pn; m_mask = mn; m_irq = in_irq; m_rxwb = rxe; m_txwb = txe;
    m_pc = tk ? 0 : m_pc + 1;
  endtask

  task automatic clear_in();
    cfg_we = 0; cfg_sel = '0; cfg_data = '0; cause_in = '0;
    tx_wb_done = 0; rx_pkt = 0; tx_pkt = 0; pend_rd = 0;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(irq == m_irq, "R9 irq vs model", irq, m_irq);
    chk(pend_o == m_pend, "R8 pend vs model", pend_o, m_pend);
    chk(rx_wb_req == m_rxwb, "R5 rx_wb_req vs model", rx_wb_req, m_rxwb);
    chk(tx_wb_req == m_txwb, "R6 tx_wb_req vs model", tx_wb_req, m_txwb);
    clear_in();
  endtask

  task automatic wr(input int sel, input int data);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_data = 16'(data);
    step();
  endtask

  task automatic wait_req(input bit is_rx, input int maxn, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!(is_rx ? rx_wb_req : tx_wb_req) && n < maxn);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, cnt;
    void'($urandom(32'h1c3d_5a77));
    clear_in();
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(posedge clk);  // synchronizer release
    @(negedge clk);
    // R12 reset state
    chk(irq == 0 && pend_o == 0 && !rx_wb_req && !tx_wb_req, "R12 reset outputs",
        {irq, pend_o, rx_wb_req, tx_wb_req}, 0);

    // R8 ordinary post of bit 0 via tx_wb_done
    wr(0, 8'h01);
    tx_wb_done = 1; step();
    chk(pend_o == 8'h01, "R8 tx_wb_done sets bit0", pend_o, 1);
    chk(irq == 1, "R8 irq after post", irq, 1);

    // R11 read clear with same-cycle post
    pend_rd = 1; cause_in = 8'h40; step();
    chk(pend_o == 8'h40, "R11 same-cycle post survives", pend_o, 8'h40);
    chk(irq == 0, "R11 irq drops", irq, 0);
    pend_rd = 1; step();
    chk(pend_o == 0, "R11 clear", pend_o, 0);

    // R10 mask write re-evaluation
    wr(0, 0);
    cause_in = 8'h20; step();
    chk(irq == 0 && pend_o == 8'h20, "R10 masked-out pending", irq, 0);
    wr(0, 8'h20);
    chk(irq == 1, "R10 enable raises line", irq, 1);
    wr(0, 0);
    chk(irq == 0 && pend_o == 8'h20, "R10 disable drops line", irq, 0);
    pend_rd = 1; step();

    // R1 value 1
    wr(0, 8'h02); wr(1, 1); wr(2, 0);
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    chk(n >= 1 && n <= D, "R1 value 1 within one tick", n, D);
    pend_rd = 1; step();

    // R2 single strobe
    wr(1, 3);
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    chk(n >= 2 * D + 1 && n <= 3 * D, "R2 expiry window", n, 3 * D);
    chk(pend_o[1] == 1, "R5 rx cause set with request", pend_o[1], 1);
    chk(irq == 1, "R7 line with rx request", irq, 1);
    pend_rd = 1; step();

    // R2 restart
    rx_pkt = 1; step();
    cnt = 0;
    repeat (2 * D) begin step(); cnt += rx_wb_req; end
    chk(cnt == 0, "R2 no early expiry", cnt, 0);
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    chk(n >= 2 * D + 1 && n <= 3 * D, "R2 restart window", n, 3 * D);
    pend_rd = 1; step();

    // R3 absolute
    wr(1, 0); wr(2, 3);
    rx_pkt = 1; step();
    repeat (D) step();
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    n = n + D + 1;
    chk(n >= 2 * D + 1 && n <= 3 * D, "R3 absolute window", n, 3 * D);
    pend_rd = 1; step();

    // R5 first expiry cancels the other rx timer
    wr(1, 2);
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    chk(n >= D + 1 && n <= 2 * D, "R5 first expiry", n, 2 * D);
    cnt = 0;
    repeat (4 * D) begin step(); cnt += rx_wb_req; end
    chk(cnt == 0, "R5 sibling cancelled", cnt, 0);
    pend_rd = 1; step();

    // R4 / R6 transmit
    wr(1, 0); wr(2, 0); wr(4, 2); wr(3, 0); wr(0, 8'h01);
    tx_pkt = 1; step();
    wait_req(0, 10 * D, n);
    chk(n >= D + 1 && n <= 2 * D, "R4 tx idle window", n, 2 * D);
    chk(pend_o[0] == 1 && irq == 1, "R6 tx cause and line", pend_o[0], 1);
    pend_rd = 1; step();
    wr(4, 0); wr(3, 2);
    tx_pkt = 1; step();
    tx_pkt = 1; step();
    wait_req(0, 10 * D, n);
    n = n + 1;
    chk(n >= D + 1 && n <= 2 * D, "R4 tx absolute window", n, 2 * D);
    pend_rd = 1; step();

    // R12 zero disables
    wr(3, 0);
    rx_pkt = 1; tx_pkt = 1; step();
    cnt = 0;
    repeat (10 * D) begin step(); cnt += rx_wb_req + tx_wb_req; end
    chk(cnt == 0, "R12 zero value disabled", cnt, 0);

    // R9 limiter deferral
    wr(5, 5); wr(0, 8'h10);
    cause_in = 8'h10; step();
    chk(irq == 1, "R9 first post raises", irq, 1);
    pend_rd = 1; step();
    chk(irq == 0, "R11 read drops line", irq, 0);
    cause_in = 8'h10; step();
    chk(irq == 0 && pend_o == 8'h10, "R9 post deferred", irq, 0);
    n = 2;
    while (!irq && n < 20 * D) begin step(); n++; end
    chk(n >= 4 * D + 1 && n <= 5 * D, "R9 deferred rise window", n, 5 * D);

    // R7 bypass under long limiter
    pend_rd = 1; step();
    wr(5, 50);
    repeat (6 * D) step();
    cause_in = 8'h10; step();
    chk(irq == 1, "R8 post after idle limiter", irq, 1);
    pend_rd = 1; step();
    wr(0, 8'h12); wr(1, 1); wr(2, 0);
    rx_pkt = 1; step();
    wait_req(1, 10 * D, n);
    chk(rx_wb_req == 1 && irq == 1, "R7 expiry bypasses limiter", irq, 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 8 == 0) cause_in = 8'(1 << ($urandom % 8));
      rx_pkt     = ($urandom % 10 == 0);
      tx_pkt     = ($urandom % 10 == 0);
      tx_wb_done = ($urandom % 20 == 0);
      pend_rd    = ($urandom % 16 == 0);
      if ($urandom % 40 == 0) begin
        cfg_we  = 1;
        cfg_sel = 3'($urandom % 6);
        if (cfg_sel == 3'd0)      cfg_data = 16'($urandom % 256);
        else if (cfg_sel == 3'd5) cfg_data = 16'($urandom % 9);
        else                      cfg_data = 16'($urandom % 7);
      end
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule